// File: doc/BRIEF.md
# Two-Port Shared Memory with Same-Word Collision Arbitration

This block is a synchronous model of a static memory with two independent ports, named left and right. Each port has its own address, write data, read data, enable, write select and output enable. Either port can read or write any word in any cycle. Reads are registered, so data appears one clock after the request. The read data bus is forced to zero whenever no qualifying read was made, and a per-port valid flag marks the cycles that carry real data.

When both ports address the same word in the same cycle and at least one of them writes, an arbiter picks a winner. The losing port sees its busy output go high, and any write it attempts is dropped. A port that was already on the word in the previous cycle keeps it against a newcomer. A collision that continues keeps its earlier loser. A fresh collision between two newcomers goes to the left port. Two reads of the same word never collide.

A mode input makes the device either a master or a slave, so identical devices can be placed side by side to build a wider word. A master computes busy itself and drives it out. A slave takes busy from the master's outputs on its busy inputs and uses those to gate its own writes.

Top module: `twin_port_ram`

## Requirements
- R1: A word written through one port (enable=1, write select=1) is returned by either port on a later read (enable=1, write select=0, output enable=1), on the read data bus one clock after the read request, with valid high.
- R2: A port's read data is zero and its valid flag is low in the cycle after any request that is not a read with output enable high, including a write and a disabled port.
- R3: Two reads of the same word in the same cycle raise no busy flag on either port and both return the stored word.
- R4: In master mode, when both ports are enabled on the same word in the same cycle, at least one writes, and neither was on that word in the previous cycle, the right busy output is high and the left busy output is low. The left write takes effect.
- R5: In master mode, a port that was enabled on a word in the previous cycle wins a collision against a port that was not. While the collision continues on both sides, the same port stays busy.
- R6: A write from a busy port does not change memory. A read from a busy port returns the word as it was before the winning port's write in that cycle.
- R7: Accesses on different words never raise busy, and writes through both ports in the same cycle both take effect.
- R8: In slave mode (master input low), each busy output equals its busy input. A high busy input blocks that port's write. A local same-word collision does not raise busy.
- R9: In master mode the busy inputs have no effect on busy outputs or on writes.
- R10: After reset, both read data buses are zero, both valid flags are low and, with both ports idle, both busy outputs are low.
- R11: A port whose enable is low never raises busy and never writes, whatever its other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1: arbitrate locally; 0: take busy from busy inputs |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_i | input | 1 | Left busy from an external master (slave mode) |
| l_busy_o | output | 1 | Left busy flag |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right write select (1 write, 0 read) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_i | input | 1 | Right busy from an external master (slave mode) |
| r_busy_o | output | 1 | Right busy flag |

## Verification
The arbiter is driven with several kinds of same-word traffic. A write against a write from two newcomers shows that the left port wins a tie. A write against a read shows that the loser reads the word as it was before the write. A port that arrives while the other already sits on the word shows that the earlier port keeps it, and holding that collision for one more cycle shows that the loser does not change. Contrasting patterns separate real collisions from the cases that must stay quiet: reads of the same word, different words, and a disabled port on the same word. Slave and master runs with the busy inputs forced high show which source gates the writes.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef struct packed {
    logic ce;
    logic we;
    logic oe;
  } port_ctl_t;

  localparam int NUM_PORTS = 2;
  localparam int LEFT_IDX  = 0;
  localparam int RIGHT_IDX = 1;

  // Same word, both enabled, and at least one side writing.
  function automatic logic word_clash(input port_ctl_t a, input port_ctl_t b,
                                      input logic same_word);
    return a.ce && b.ce && same_word && (a.we || b.we);
  endfunction

  // A port qualifies for read data when enabled, reading, output on.
  function automatic logic read_qualifies(input port_ctl_t c);
    return c.ce && c.oe && !c.we;
  endfunction

  // Decide whether the left side yields a clash.
  // Earlier occupant wins; an ongoing clash keeps its loser; else left wins.
  function automatic logic left_yields(input logic held_l, input logic held_r,
                                       input logic prev_clash,
                                       input logic prev_left_lost);
    logic res;
    if (held_r && !held_l)      res = 1'b1;
    else if (held_l && !held_r) res = 1'b0;
    else if (held_l && held_r && prev_clash) res = prev_left_lost;
    else                        res = 1'b0;
    return res;
  endfunction

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  port_ctl_t         ctl_l,
  input  port_ctl_t         ctl_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              busy_in_l,
  input  logic              busy_in_r,
  output logic              busy_l,
  output logic              busy_r,
  output logic              clash,
  output logic              wr_en_l,
  output logic              wr_en_r
);

  logic              prev_ce_l, prev_ce_r;
  logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;
  logic              prev_clash;
  logic              prev_left_lost;

  logic held_l, held_r;
  logic left_lost;
  logic loc_busy_l, loc_busy_r;

  assign clash     = word_clash(ctl_l, ctl_r, addr_l == addr_r);
  assign held_l    = prev_ce_l && (prev_addr_l == addr_l);
  assign held_r    = prev_ce_r && (prev_addr_r == addr_r);
  assign left_lost = left_yields(held_l, held_r, prev_clash, prev_left_lost);

  assign loc_busy_l = clash && left_lost;
  assign loc_busy_r = clash && !left_lost;

  assign busy_l = is_master ? loc_busy_l : busy_in_l;
  assign busy_r = is_master ? loc_busy_r : busy_in_r;

  assign wr_en_l = ctl_l.ce && ctl_l.we && !busy_l;
  assign wr_en_r = ctl_r.ce && ctl_r.we && !busy_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ce_l      <= 1'b0;
      prev_ce_r      <= 1'b0;
      prev_addr_l    <= '0;
      prev_addr_r    <= '0;
      prev_clash     <= 1'b0;
      prev_left_lost <= 1'b0;
    end else begin
      prev_ce_l      <= ctl_l.ce;
      prev_ce_r      <= ctl_r.ce;
      prev_addr_l    <= addr_l;
      prev_addr_r    <= addr_r;
      prev_clash     <= clash;
      prev_left_lost <= clash && left_lost;
    end
  end

endmodule

// File: rtl/dpr_array.sv
module dpr_array
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic                            clk,
  input  logic [NUM_PORTS-1:0]            wr_en,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rraw
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // One process writes both ports; the higher index wins a same-word tie.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (wr_en[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
    assign rraw[g] = mem[addr[g]];
  end

endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rd_en ? raw : '0;
      rvalid <= rd_en;
    end
  end

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  input  logic              r_busy_i,
  output logic              r_busy_o
);

  port_ctl_t ctl_l, ctl_r;
  port_ctl_t [NUM_PORTS-1:0] ctl;
  logic clash;
  logic wr_en_l, wr_en_r;

  logic [NUM_PORTS-1:0]             wr_en;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr;
  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rraw;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rdata;
  logic [NUM_PORTS-1:0]             rvalid;

  assign ctl_l = '{ce: l_ce, we: l_we, oe: l_oe};
  assign ctl_r = '{ce: r_ce, we: r_we, oe: r_oe};

  assign ctl[LEFT_IDX]    = ctl_l;
  assign ctl[RIGHT_IDX]   = ctl_r;
  assign addr[LEFT_IDX]   = l_addr;
  assign addr[RIGHT_IDX]  = r_addr;
  assign wdata[LEFT_IDX]  = l_wdata;
  assign wdata[RIGHT_IDX] = r_wdata;
  assign wr_en[LEFT_IDX]  = wr_en_l;
  assign wr_en[RIGHT_IDX] = wr_en_r;

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_master (is_master),
    .ctl_l     (ctl_l),
    .ctl_r     (ctl_r),
    .addr_l    (l_addr),
    .addr_r    (r_addr),
    .busy_in_l (l_busy_i),
    .busy_in_r (r_busy_i),
    .busy_l    (l_busy_o),
    .busy_r    (r_busy_o),
    .clash     (clash),
    .wr_en_l   (wr_en_l),
    .wr_en_r   (wr_en_r)
  );

  dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rraw  (rraw)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_out
    dpr_port_out #(.DATA_W(DATA_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (read_qualifies(ctl[g])),
      .raw    (rraw[g]),
      .rdata  (rdata[g]),
      .rvalid (rvalid[g])
    );
  end

  assign l_rdata  = rdata[LEFT_IDX];
  assign r_rdata  = rdata[RIGHT_IDX];
  assign l_rvalid = rvalid[LEFT_IDX];
  assign r_rvalid = rvalid[RIGHT_IDX];

endmodule

// File: rtl/twin_port_ram_chk.sv
module twin_port_ram_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              is_master,
  input logic              l_ce,
  input logic              l_we,
  input logic              l_oe,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_rvalid,
  input logic              l_busy_i,
  input logic              l_busy_o,
  input logic              r_ce,
  input logic              r_we,
  input logic              r_oe,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_rvalid,
  input logic              r_busy_i,
  input logic              r_busy_o,
  input logic              clash,
  input logic              wr_en_l,
  input logic              wr_en_r
);

  // R4
  one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && clash |-> $countones({l_busy_o, r_busy_o}) == 1);

  // R3
  shared_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && l_ce && r_ce && !l_we && !r_we && (l_addr == r_addr)
      |-> !l_busy_o && !r_busy_o);

  // R8
  slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (l_busy_o == l_busy_i) && (r_busy_o == r_busy_i));

  // R6
  busy_l_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy_o |-> !wr_en_l);

  // R6
  busy_r_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy_o |-> !wr_en_r);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && (!l_ce || !r_ce) |-> !l_busy_o && !r_busy_o);

  // R2
  l_valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_rvalid |-> $past(l_ce && l_oe && !l_we));

  // R2
  r_valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_rvalid |-> $past(r_ce && r_oe && !r_we));

  // R2
  zero_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_rvalid |-> l_rdata == '0) and (!r_rvalid |-> r_rdata == '0));

endmodule

bind twin_port_ram twin_port_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .is_master (is_master),
  .l_ce      (l_ce),
  .l_we      (l_we),
  .l_oe      (l_oe),
  .l_addr    (l_addr),
  .l_rdata   (l_rdata),
  .l_rvalid  (l_rvalid),
  .l_busy_i  (l_busy_i),
  .l_busy_o  (l_busy_o),
  .r_ce      (r_ce),
  .r_we      (r_we),
  .r_oe      (r_oe),
  .r_addr    (r_addr),
  .r_rdata   (r_rdata),
  .r_rvalid  (r_rvalid),
  .r_busy_i  (r_busy_i),
  .r_busy_o  (r_busy_o),
  .clash     (clash),
  .wr_en_l   (wr_en_l),
  .wr_en_r   (wr_en_r)
);

// File: tb/twin_port_ram_tb.sv
module twin_port_ram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic l_ce = 0, l_we = 0, l_oe = 0, l_busy_i = 0;
  logic r_ce = 0, r_we = 0, r_oe = 0, r_busy_i = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_busy_o, r_busy_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_l(input logic ce, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce = ce; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(input logic ce, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce = ce; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    set_l(0, 0, 0, '0, '0);
    set_r(0, 0, 0, '0, '0);
  endtask

  task automatic wr_l(input logic [AW-1:0] a, input logic [DW-1:0] d);
    set_l(1, 1, 0, a, d); tick(); idle(); tick();
  endtask

  task automatic rd_l(input string req, input logic [AW-1:0] a, input logic [DW-1:0] e);
    set_l(1, 0, 1, a, '0); tick();
    chk(req, "l_rdata", l_rdata, e);
    chk(req, "l_rvalid", l_rvalid, 1);
    idle(); tick();
  endtask

  task automatic rd_r(input string req, input logic [AW-1:0] a, input logic [DW-1:0] e);
    set_r(1, 0, 1, a, '0); tick();
    chk(req, "r_rdata", r_rdata, e);
    chk(req, "r_rvalid", r_rvalid, 1);
    idle(); tick();
  endtask

  // R10
  task automatic t_reset();
    idle();
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk("R10", "l_rdata", l_rdata, 0);
    chk("R10", "r_rdata", r_rdata, 0);
    chk("R10", "l_rvalid", l_rvalid, 0);
    chk("R10", "r_rvalid", r_rvalid, 0);
    chk("R10", "busy", {l_busy_o, r_busy_o}, 0);
    tick();
  endtask

  // R1
  task automatic t_write_read();
    wr_l(12'h005, 9'h1A5);
    rd_r("R1", 12'h005, 9'h1A5);
    set_r(1, 1, 0, 12'h007, 9'h03C); tick(); idle(); tick();
    rd_l("R1", 12'h007, 9'h03C);
  endtask

  // R2
  task automatic t_gate();
    wr_l(12'h080, 9'h0F0);
    set_l(1, 0, 0, 12'h080, '0); tick();
    chk("R2", "l_rdata oe low", l_rdata, 0);
    chk("R2", "l_rvalid oe low", l_rvalid, 0);
    set_l(1, 1, 1, 12'h081, 9'h003); tick();
    chk("R2", "l_rdata on write", l_rdata, 0);
    chk("R2", "l_rvalid on write", l_rvalid, 0);
    idle(); tick();
    chk("R2", "l_rvalid idle", l_rvalid, 0);
    rd_l("R2", 12'h080, 9'h0F0);
    rd_l("R2", 12'h081, 9'h003);
  endtask

  // R3
  task automatic t_dual_read();
    wr_l(12'h070, 9'h155);
    set_l(1, 0, 1, 12'h070, '0); set_r(1, 0, 1, 12'h070, '0);
    #1;
    chk("R3", "busy both reading", {l_busy_o, r_busy_o}, 0);
    tick();
    chk("R3", "l_rdata", l_rdata, 9'h155);
    chk("R3", "r_rdata", r_rdata, 9'h155);
    idle(); tick();
  endtask

  // R4, R6
  task automatic t_collide();
    wr_l(12'h020, 9'h011);
    set_l(1, 1, 0, 12'h020, 9'h022); set_r(1, 1, 0, 12'h020, 9'h033);
    #1;
    chk("R4", "l_busy_o", l_busy_o, 0);
    chk("R4", "r_busy_o", r_busy_o, 1);
    tick(); idle(); tick();
    rd_l("R4", 12'h020, 9'h022);
    set_l(1, 1, 0, 12'h020, 9'h044); set_r(1, 0, 1, 12'h020, '0);
    #1;
    chk("R6", "r_busy_o on read", r_busy_o, 1);
    tick();
    chk("R6", "r_rdata old word", r_rdata, 9'h022);
    chk("R6", "r_rvalid", r_rvalid, 1);
    idle(); tick();
    rd_r("R6", 12'h020, 9'h044);
  endtask

  // R5
  task automatic t_hold();
    set_r(1, 0, 1, 12'h030, '0); tick();
    set_r(1, 1, 0, 12'h030, 9'h055); set_l(1, 1, 0, 12'h030, 9'h066);
    #1;
    chk("R5", "l_busy_o newcomer", l_busy_o, 1);
    chk("R5", "r_busy_o holder", r_busy_o, 0);
    tick();
    #1;
    chk("R5", "l_busy_o continued", l_busy_o, 1);
    chk("R5", "r_busy_o continued", r_busy_o, 0);
    tick(); idle(); tick();
    rd_l("R5", 12'h030, 9'h055);
  endtask

  // R7
  task automatic t_diff();
    set_l(1, 1, 0, 12'h060, 9'h0AB); set_r(1, 1, 0, 12'h061, 9'h1CD);
    #1;
    chk("R7", "busy different words", {l_busy_o, r_busy_o}, 0);
    tick(); idle(); tick();
    rd_l("R7", 12'h060, 9'h0AB);
    rd_r("R7", 12'h061, 9'h1CD);
  endtask

  // R8
  task automatic t_slave();
    wr_l(12'h040, 9'h001);
    wr_l(12'h042, 9'h000);
    is_master = 1'b0; l_busy_i = 1'b1;
    set_l(1, 1, 0, 12'h040, 9'h077);
    #1;
    chk("R8", "l_busy_o from input", l_busy_o, 1);
    chk("R8", "r_busy_o from input", r_busy_o, 0);
    tick(); idle(); l_busy_i = 1'b0; tick();
    set_l(1, 1, 0, 12'h042, 9'h012); set_r(1, 0, 1, 12'h042, '0);
    #1;
    chk("R8", "no local busy in slave", {l_busy_o, r_busy_o}, 0);
    tick(); idle(); is_master = 1'b1; tick();
    rd_l("R8", 12'h040, 9'h001);
    rd_l("R8", 12'h042, 9'h012);
  endtask

  // R9
  task automatic t_master_ignore();
    is_master = 1'b1; l_busy_i = 1'b1; r_busy_i = 1'b1;
    set_l(1, 1, 0, 12'h041, 9'h0AA);
    #1;
    chk("R9", "busy inputs ignored", {l_busy_o, r_busy_o}, 0);
    tick(); idle(); tick();
    l_busy_i = 1'b0; r_busy_i = 1'b0;
    rd_l("R9", 12'h041, 9'h0AA);
  endtask

  // R11
  task automatic t_disabled();
    wr_l(12'h050, 9'h05A);
    wr_l(12'h051, 9'h033);
    set_l(1, 1, 0, 12'h050, 9'h0A5); set_r(0, 1, 1, 12'h050, 9'h1FF);
    #1;
    chk("R11", "busy with right disabled", {l_busy_o, r_busy_o}, 0);
    tick(); idle(); tick();
    rd_r("R11", 12'h050, 9'h0A5);
    set_r(0, 1, 0, 12'h051, 9'h1EE); tick(); idle(); tick();
    rd_r("R11", 12'h051, 9'h033);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_read();
    t_gate();
    t_dual_read();
    t_collide();
    t_hold();
    t_diff();
    t_slave();
    t_master_ignore();
    t_disabled();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule